// File: doc/BRIEF.md
# Channel Source Burst Sequencer

This block is the control state machine on the sending side of a point-to-point parallel data channel. It pulls words from a host FIFO. It first sends a connection header word while it asks for the channel. Once the channel is connected, it sends packets split into bursts. The machine decides each cycle whether to read the FIFO, and it drives the channel request line and the packet and burst framing. It also flags errors caused by the receiver and errors caused by the host. The data and parity pipeline, the check-word arithmetic and the electrical interface are handled elsewhere. The `chk_slot_o` output marks the one cycle in which that other logic inserts the check word.

A connection attempt begins when the host requests a connection and the FIFO holds data. The FIFO is read until the header-word flag is seen. The header is then held on the channel with the request line raised until the receiver acknowledges. From then on, the FIFO words are sorted in two ways:

- Words outside a packet are skipped through an idle/wait loop, with framing held low.
- Words inside a packet are grouped into bursts.

A burst holds at most `BURST_MAX` words. It ends early on a host end-of-burst mark, on an empty FIFO, or when the packet ends. A burst starts only when flow control says the receiver can take a full burst.

Top module: `chan_src_burst_seq`

## Requirements
- R1: An active-low `rst_n`, or `disc_i` high at a clock edge, puts the machine in the initial state. In that state `fifo_rd_n_o` is 1 and `chan_req_o`, `pkt_frame_o`, `burst_frame_o`, `chk_slot_o`, `dest_err_o` and `src_err_o` are all 0.
- R2: The initial state holds while `conn_req_i` is high and `fifo_data_av_i` is low. When both are high, the machine moves to header reading.
- R3: During header reading, `fifo_rd_n_o` is 0 on every cycle until `hdr_det_i` is seen. The next state is header posting, with `fifo_rd_n_o` = 1 and `chan_req_o` = 1.
- R4: `conn_ack_i` in the initial state or in header reading moves to the receiver-error state, with `dest_err_o` = 1. In header posting it moves to idle. In every other state it has no effect.
- R5: `chan_req_o` is 1 in header posting and in every connected state from idle through check-word. It is 0 in the initial, header-reading and error states.
- R6: Idle performs no reads. It moves to wait-packet when `fifo_burst_av_i` and `fifo_data_av_i` are both 1.
- R7: Wait-packet reads for exactly one cycle. If `fifo_pkt_av_i` is 0 in that cycle, the machine returns to idle with `pkt_frame_o` = 0. If it is 1, the machine goes to pending-burst.
- R8: Pending-burst performs no reads. `fifo_pkt_av_i` = 0 sends it to the source-error state, with `src_err_o` = 1, and this takes priority over flow control. Otherwise it holds while `rx_not_ready_i` is 1.
- R9: When pending-burst is released, the next state is last-word if `fifo_burst_end_i` is 1 or `fifo_data_av_i` is 0. Otherwise it is burst.
- R10: Burst reads on every cycle. It ends when `fifo_pkt_av_i` = 0, `fifo_burst_end_i` = 1, `fifo_data_av_i` = 0, or after `BURST_MAX`-1 burst-state reads. With the wait-packet word included, a burst therefore never exceeds `BURST_MAX` (256) words.
- R11: Last-word lasts exactly one cycle, with `fifo_rd_n_o` = 1 and `burst_frame_o` = 1, and is always followed by check-word.
- R12: Check-word lasts one cycle with `chk_slot_o` = 1. It then goes to wait-packet if `fifo_pkt_av_i` is 1, or to idle if it is 0.
- R13: Both error states hold, with their flag high, until reset or disconnect.
- R14: `pkt_frame_o` is 1 exactly in pending-burst, burst, last-word and check-word. `burst_frame_o` is 1 exactly in burst and last-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_i | input | 1 | Channel disconnected; forces the initial state |
| conn_req_i | input | 1 | Host requests a connection |
| conn_ack_i | input | 1 | Receiver acknowledges the connection |
| hdr_det_i | input | 1 | The word being read is the connection header |
| fifo_data_av_i | input | 1 | Host FIFO holds data |
| fifo_pkt_av_i | input | 1 | Current FIFO word lies inside a packet |
| fifo_burst_av_i | input | 1 | Host has a burst ready |
| fifo_burst_end_i | input | 1 | Current FIFO word ends the host's burst |
| rx_not_ready_i | input | 1 | Receiver cannot take a full burst yet |
| fifo_rd_n_o | output | 1 | Active-low FIFO read enable |
| chan_req_o | output | 1 | Channel request line |
| pkt_frame_o | output | 1 | Packet framing |
| burst_frame_o | output | 1 | Burst framing |
| chk_slot_o | output | 1 | Check-word slot marker |
| dest_err_o | output | 1 | Receiver-side error |
| src_err_o | output | 1 | Host-side error |

## Verification
The packet path is driven with four patterns:

- **Non-packet words.** These must loop between idle and wait-packet with no framing, which separates the skip path from the burst path.
- **A first word marked as burst end.** This takes the single-word route through last-word.
- **A burst ended by the host mark after three burst reads.** This shows that the counted reads and the check-word return to wait-packet both work.
- **A burst with no ending condition at all.** This must stop after exactly 255 burst-state reads, which isolates the length cap from the other terminations.

The header phase is tried with data absent, then present. A connection acknowledge is applied early, on time and late, which separates the error, connect and ignore responses. The errors are checked for stickiness and for clearing on disconnect.

// File: rtl/csb_pkg.sv
package csb_pkg;

   typedef enum logic [3:0] {
      ST_INIT       = 4'd0,
      ST_RD_HDR     = 4'd1,
      ST_POST_HDR   = 4'd2,
      ST_IDLE       = 4'd3,
      ST_WAIT_PKT   = 4'd4,
      ST_PEND_BURST = 4'd5,
      ST_BURST      = 4'd6,
      ST_LAST_WORD  = 4'd7,
      ST_CHECK      = 4'd8,
      ST_DEST_ERR   = 4'd9,
      ST_SRC_ERR    = 4'd10
   } csb_state_e;

   typedef struct packed {
      logic disc;
      logic conn_req;
      logic conn_ack;
      logic hdr_det;
      logic data_av;
      logic pkt_av;
      logic burst_av;
      logic burst_end;
      logic rx_not_ready;
   } csb_in_t;

   typedef struct packed {
      logic rd_n;
      logic req;
      logic pkt_frame;
      logic burst_frame;
      logic chk_slot;
      logic dest_err;
      logic src_err;
   } csb_out_t;

endpackage

// File: rtl/csb_word_counter.sv
module csb_word_counter #(
   parameter int BURST_MAX  = 256,
   parameter bit DOWN_COUNT = 1'b0,
   localparam int CNT_W     = $clog2(BURST_MAX)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_burst,
   output logic at_last
);

   generate
      if (BURST_MAX < 2) begin : g_bad_max
         $error("csb_word_counter: BURST_MAX must be at least 2");
      end

      if (DOWN_COUNT) begin : g_down
         // Remaining burst-state reads before the limit word
         localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(BURST_MAX - 2);
         logic [CNT_W-1:0] remain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         remain_q <= LOAD_V;
            else if (!in_burst) remain_q <= LOAD_V;
            else                remain_q <= remain_q - 1'b1;
         end
         assign at_last = (remain_q == '0);
      end else begin : g_up
         // Words of the burst read so far, the wait-packet word counted as one
         localparam logic [CNT_W-1:0] LAST_V = CNT_W'(BURST_MAX - 1);
         logic [CNT_W-1:0] words_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         words_q <= CNT_W'(1);
            else if (!in_burst) words_q <= CNT_W'(1);
            else                words_q <= words_q + 1'b1;
         end
         assign at_last = (words_q == LAST_V);
      end
   endgenerate

endmodule

// File: rtl/csb_next_state.sv
module csb_next_state
   import csb_pkg::*;
(
   input  csb_state_e cur,
   input  csb_in_t    in,
   input  logic       burst_at_last,
   output csb_state_e nxt
);

   logic burst_done;
   assign burst_done = !in.pkt_av || in.burst_end || !in.data_av || burst_at_last;

   always_comb begin
      nxt = cur;
      if (in.disc) begin
         nxt = ST_INIT;
      end else begin
         unique case (cur)
            ST_INIT: begin
               if (in.conn_ack)                     nxt = ST_DEST_ERR;
               else if (in.conn_req && in.data_av)  nxt = ST_RD_HDR;
            end
            ST_RD_HDR: begin
               if (in.conn_ack)      nxt = ST_DEST_ERR;
               else if (in.hdr_det)  nxt = ST_POST_HDR;
            end
            ST_POST_HDR: begin
               if (in.conn_ack) nxt = ST_IDLE;
            end
            ST_IDLE: begin
               if (in.burst_av && in.data_av) nxt = ST_WAIT_PKT;
            end
            ST_WAIT_PKT: begin
               nxt = in.pkt_av ? ST_PEND_BURST : ST_IDLE;
            end
            ST_PEND_BURST: begin
               if (!in.pkt_av)                         nxt = ST_SRC_ERR;
               else if (in.rx_not_ready)               nxt = ST_PEND_BURST;
               else if (in.burst_end || !in.data_av)   nxt = ST_LAST_WORD;
               else                                    nxt = ST_BURST;
            end
            ST_BURST: begin
               if (burst_done) nxt = ST_LAST_WORD;
            end
            ST_LAST_WORD: nxt = ST_CHECK;
            ST_CHECK: begin
               nxt = in.pkt_av ? ST_WAIT_PKT : ST_IDLE;
            end
            ST_DEST_ERR: nxt = ST_DEST_ERR;
            ST_SRC_ERR:  nxt = ST_SRC_ERR;
            default:     nxt = ST_INIT;
         endcase
      end
   end

endmodule

// File: rtl/csb_out_decode.sv
module csb_out_decode
   import csb_pkg::*;
(
   input  csb_state_e cur,
   output csb_out_t   out
);

   always_comb begin
      out             = '0;
      out.rd_n        = 1'b1;
      unique case (cur)
         ST_RD_HDR:     out.rd_n = 1'b0;
         ST_POST_HDR:   out.req  = 1'b1;
         ST_IDLE:       out.req  = 1'b1;
         ST_WAIT_PKT: begin
            out.req  = 1'b1;
            out.rd_n = 1'b0;
         end
         ST_PEND_BURST: begin
            out.req       = 1'b1;
            out.pkt_frame = 1'b1;
         end
         ST_BURST: begin
            out.req         = 1'b1;
            out.rd_n        = 1'b0;
            out.pkt_frame   = 1'b1;
            out.burst_frame = 1'b1;
         end
         ST_LAST_WORD: begin
            out.req         = 1'b1;
            out.pkt_frame   = 1'b1;
            out.burst_frame = 1'b1;
         end
         ST_CHECK: begin
            out.req       = 1'b1;
            out.pkt_frame = 1'b1;
            out.chk_slot  = 1'b1;
         end
         ST_DEST_ERR:   out.dest_err = 1'b1;
         ST_SRC_ERR:    out.src_err  = 1'b1;
         default:       out.rd_n     = 1'b1;
      endcase
   end

endmodule

// File: rtl/chan_src_burst_seq.sv
module chan_src_burst_seq
   import csb_pkg::*;
#(
   parameter int BURST_MAX  = 256,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic disc_i,
   input  logic conn_req_i,
   input  logic conn_ack_i,
   input  logic hdr_det_i,
   input  logic fifo_data_av_i,
   input  logic fifo_pkt_av_i,
   input  logic fifo_burst_av_i,
   input  logic fifo_burst_end_i,
   input  logic rx_not_ready_i,
   output logic fifo_rd_n_o,
   output logic chan_req_o,
   output logic pkt_frame_o,
   output logic burst_frame_o,
   output logic chk_slot_o,
   output logic dest_err_o,
   output logic src_err_o
);

   csb_state_e state_q;
   csb_state_e state_d;
   csb_in_t    in_s;
   csb_out_t   out_s;
   logic       burst_at_last;

   assign in_s.disc         = disc_i;
   assign in_s.conn_req     = conn_req_i;
   assign in_s.conn_ack     = conn_ack_i;
   assign in_s.hdr_det      = hdr_det_i;
   assign in_s.data_av      = fifo_data_av_i;
   assign in_s.pkt_av       = fifo_pkt_av_i;
   assign in_s.burst_av     = fifo_burst_av_i;
   assign in_s.burst_end    = fifo_burst_end_i;
   assign in_s.rx_not_ready = rx_not_ready_i;

   csb_word_counter #(
      .BURST_MAX  (BURST_MAX),
      .DOWN_COUNT (DOWN_COUNT)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_burst (state_q == ST_BURST),
      .at_last  (burst_at_last)
   );

   csb_next_state u_nxt (
      .cur           (state_q),
      .in            (in_s),
      .burst_at_last (burst_at_last),
      .nxt           (state_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_INIT;
      else        state_q <= state_d;
   end

   csb_out_decode u_dec (
      .cur (state_q),
      .out (out_s)
   );

   assign fifo_rd_n_o   = out_s.rd_n;
   assign chan_req_o    = out_s.req;
   assign pkt_frame_o   = out_s.pkt_frame;
   assign burst_frame_o = out_s.burst_frame;
   assign chk_slot_o    = out_s.chk_slot;
   assign dest_err_o    = out_s.dest_err;
   assign src_err_o     = out_s.src_err;

endmodule

// File: rtl/csb_checker.sv
module csb_checker
   import csb_pkg::*;
#(
   parameter int BURST_MAX = 256,
   localparam int RUN_W    = $clog2(BURST_MAX) + 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       disc_i,
   input logic       conn_ack_i,
   input logic       fifo_rd_n_o,
   input logic       chan_req_o,
   input logic       burst_frame_o,
   input logic       dest_err_o,
   input logic       src_err_o,
   input csb_state_e state_q
);

   // Consecutive burst-state reads, for the length cap
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   run_q <= '0;
      else if (burst_frame_o && !fifo_rd_n_o)       run_q <= run_q + 1'b1;
      else                                          run_q <= '0;
   end

   a_r1_disc_to_init: assert property (@(posedge clk) disable iff (!rst_n)
      disc_i |=> (fifo_rd_n_o && !chan_req_o && !dest_err_o && !src_err_o));

   a_r3_header_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD_HDR) |-> !fifo_rd_n_o);

   a_r4_early_ack_error: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_INIT || state_q == ST_RD_HDR) && conn_ack_i && !disc_i)
      |=> dest_err_o);

   a_r7_single_wait_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_PKT) |=> fifo_rd_n_o);

   a_r10_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(BURST_MAX - 1));

   a_r11_last_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LAST_WORD && !disc_i) |=> (state_q == ST_CHECK));

   a_r13_dest_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_err_o && !disc_i) |=> dest_err_o);

   a_r13_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (src_err_o && !disc_i) |=> src_err_o);

   a_r5_no_req_in_error: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_err_o || src_err_o) |-> !chan_req_o);

endmodule

bind chan_src_burst_seq csb_checker #(.BURST_MAX(BURST_MAX)) u_csb_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .disc_i        (disc_i),
   .conn_ack_i    (conn_ack_i),
   .fifo_rd_n_o   (fifo_rd_n_o),
   .chan_req_o    (chan_req_o),
   .burst_frame_o (burst_frame_o),
   .dest_err_o    (dest_err_o),
   .src_err_o     (src_err_o),
   .state_q       (state_q)
);

// File: tb/chan_src_burst_seq_tb.sv
`timescale 1ns/1ps
module chan_src_burst_seq_tb_top;

   localparam int BURST_MAX = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disc, creq, cack, hdr, dav, pav, bav, bend, rxnr;
   logic rd_n, req, pfr, bfr, chk, derr, serr;
   int   checks = 0;
   int   fails  = 0;

   always #10 clk = ~clk;

   chan_src_burst_seq #(.BURST_MAX(BURST_MAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .disc_i(disc), .conn_req_i(creq),
      .conn_ack_i(cack), .hdr_det_i(hdr), .fifo_data_av_i(dav),
      .fifo_pkt_av_i(pav), .fifo_burst_av_i(bav), .fifo_burst_end_i(bend),
      .rx_not_ready_i(rxnr), .fifo_rd_n_o(rd_n), .chan_req_o(req),
      .pkt_frame_o(pfr), .burst_frame_o(bfr), .chk_slot_o(chk),
      .dest_err_o(derr), .src_err_o(serr)
   );

   task automatic chk1(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // Outputs packed as {rd_n, req, pfr, bfr, chk, derr, serr}
   task automatic chk_outs(string tag, logic [6:0] exp);
      checks++;
      if ({rd_n, req, pfr, bfr, chk, derr, serr} !== exp) begin
         fails++;
         $display("FAIL %s outputs actual=%b expected=%b", tag,
                  {rd_n, req, pfr, bfr, chk, derr, serr}, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_in();
      disc = 0; creq = 0; cack = 0; hdr = 0; dav = 0;
      pav = 0; bav = 0; bend = 0; rxnr = 0;
   endtask

   task automatic do_disc();
      clear_in();
      disc = 1;
      step();
      disc = 0;
   endtask

   task automatic go_idle();
      do_disc();
      creq = 1; dav = 1; step();
      hdr = 1; step();
      hdr = 0; cack = 1; step();
      cack = 0; creq = 0; dav = 0;
   endtask

   // From idle to pending-burst, receiver held not ready
   task automatic go_pend();
      go_idle();
      bav = 1; dav = 1; pav = 1; rxnr = 1; step();
      step();
   endtask

   task automatic t_reset();
      chk_outs("R1 reset", 7'b1000000);
   endtask

   task automatic t_connect();
      do_disc();
      creq = 1; dav = 0; step();
      chk_outs("R2 hold without data", 7'b1000000);
      dav = 1; step();
      chk_outs("R3 header read", 7'b0000000);
      step();
      chk1("R3", "read continues", rd_n, 1'b0);
      hdr = 1; step();
      chk_outs("R3 header posted", 7'b1100000);
      hdr = 0; step();
      chk1("R5", "request held while waiting", req, 1'b1);
      cack = 1; step();
      cack = 0;
      chk_outs("R4 ack to idle", 7'b1100000);
      step();
      chk_outs("R6 idle no read", 7'b1100000);
   endtask

   task automatic t_early_ack();
      do_disc();
      cack = 1; step();
      chk_outs("R4 ack in init", 7'b1000010);
      cack = 0; step(); step();
      chk1("R13", "dest error sticky", derr, 1'b1);
      do_disc();
      chk_outs("R1 disc clears dest error", 7'b1000000);
      creq = 1; dav = 1; step();
      cack = 1; step();
      chk_outs("R4 ack in header read", 7'b1000010);
   endtask

   task automatic t_ack_ignored();
      go_idle();
      cack = 1; step();
      chk_outs("R4 ack ignored in idle", 7'b1100000);
      cack = 0; bav = 1; dav = 1; step();
      chk1("R6", "wait-packet reads", rd_n, 1'b0);
   endtask

   task automatic t_skip_loop();
      go_idle();
      bav = 1; dav = 1; pav = 0; step();
      chk_outs("R7 wait read no framing", 7'b0100000);
      step();
      chk_outs("R7 back to idle", 7'b1100000);
      bav = 0; step();
      chk_outs("R6 idle holds", 7'b1100000);
   endtask

   task automatic t_single_word();
      go_pend();
      bend = 1;
      chk_outs("R8 pending no read", 7'b1110000);
      step();
      chk_outs("R8 held by flow control", 7'b1110000);
      rxnr = 0; step();
      chk_outs("R9 single word to last", 7'b1111000);
      chk1("R14", "burst frame in last word", bfr, 1'b1);
      pav = 0; step();
      chk_outs("R11 check word follows", 7'b1110100);
      step();
      chk_outs("R12 to idle after packet", 7'b1100000);
   endtask

   task automatic t_empty_pend();
      go_pend();
      rxnr = 0; dav = 0; step();
      chk1("R9", "empty fifo single word", bfr & rd_n, 1'b1);
   endtask

   task automatic t_short_burst();
      int n;
      go_pend();
      rxnr = 0; step();
      chk_outs("R10 burst reads", 7'b0111000);
      n = 1;
      step(); n++;
      step(); n++;
      chk1("R10", "still reading at third", rd_n, 1'b0);
      bend = 1; step();
      bend = 0;
      chk_outs("R11 last after mark", 7'b1111000);
      chk1("R10", "three burst reads", (n == 3), 1'b1);
      step();
      chk1("R12", "check slot", chk, 1'b1);
      step();
      chk_outs("R12 back to wait with packet", 7'b0100000);
   endtask

   task automatic t_cap();
      int n = 0;
      go_pend();
      rxnr = 0; step();
      for (int i = 0; i < 400; i++) begin
         if (bfr && !rd_n) n++;
         else break;
         step();
      end
      chk1("R10", "cap stops burst", (n == BURST_MAX - 1), 1'b1);
      if (n != BURST_MAX - 1)
         $display("FAIL R10 burst reads actual=%0d expected=%0d", n, BURST_MAX - 1);
      chk_outs("R11 last after cap", 7'b1111000);
   endtask

   task automatic t_pkt_end_in_burst();
      go_pend();
      rxnr = 0; step();
      step();
      pav = 0; step();
      chk_outs("R10 packet end stops burst", 7'b1111000);
      step(); step();
      chk_outs("R12 idle after packet end", 7'b1100000);
   endtask

   task automatic t_src_err();
      go_pend();
      pav = 0; step();
      chk_outs("R8 source error", 7'b1000001);
      step(); step();
      chk1("R13", "source error sticky", serr, 1'b1);
      do_disc();
      chk_outs("R1 disc clears source error", 7'b1000000);
   endtask

   task automatic t_disc_in_burst();
      go_pend();
      rxnr = 0; step();
      disc = 1; step();
      disc = 0;
      chk_outs("R1 disc during burst", 7'b1000000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      clear_in();
      #35;
      rst_n = 1;
      #1;
      t_reset();
      t_connect();
      t_early_ack();
      t_ack_ignored();
      t_skip_loop();
      t_single_word();
      t_empty_pend();
      t_short_burst();
      t_cap();
      t_pkt_end_in_burst();
      t_src_err();
      t_disc_in_burst();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule